// File: doc/BRIEF.md
# Rewindable Dual-Mode FIFO

This block is a 9-bit FIFO whose write and read sides run on separate clocks. Each side keeps a binary pointer one bit wider than the storage address. The pointer crosses to the other side as a Gray code through a two-flop synchronizer, and each side works out its own status flag locally. The output word sits in a register on the read clock.

A master reset clears everything. While it is held, the block samples `fwft_sel_i` to choose one of two output timing modes:

- **Standard mode:** a word reaches `rdata_o` only after a read request.
- **Fall-through mode:** the oldest stored word moves into the output register by itself and is marked valid.

A partial reset clears the pointers and the output register but keeps the chosen mode. The retransmit input `rt_i` rewinds only the read pointer to the first physical location, so data written since the last reset can be read again.

Top module: `rewind_fifo`

## Requirements
- R1: While `mrst_n` is low, the mode is sampled from `fwft_sel_i` (1 = fall-through, 0 = standard), both pointers go to zero and `rdata_o` reads 0.
- R2: The sampled mode stays fixed until the next master reset. Changing `fwft_sel_i` outside master reset, or asserting `prst_n`, has no effect on the mode.
- R3: While `prst_n` is low, both pointers return to zero and `rdata_o` reads 0.
- R4: In standard mode, `wflag_o` means full: it is 1 exactly when DEPTH words are stored. `rflag_o` means empty: it is 1 when no word is stored.
- R5: In standard mode, a read (`ren_i`=1 while not empty) places the oldest word on `rdata_o` at that read-clock edge. Without a read, `rdata_o` keeps its value. Words come out in write order.
- R6: In fall-through mode, the oldest word appears on `rdata_o` with `rflag_o`=1 (output ready) without any read request. A read consumes it. `wflag_o`=1 means space is available (input ready). The total capacity is DEPTH+1 words, counting the output register.
- R7: A write while full is ignored and leaves the write pointer unchanged. A read while empty (standard mode) is ignored and leaves `rdata_o` unchanged.
- R8: `rt_i`=1 at a rising read-clock edge sets the read pointer to zero and leaves the write pointer untouched. Words written since the last reset are then delivered again from the first one, followed by any words written later.
- R9: After a retransmit, for RT_HOLD read-clock cycles starting at that edge, `rflag_o` is forced to 1 (empty) in standard mode or to 0 (not ready) in fall-through mode, and no word is read or loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| fwft_sel_i | input | 1 | Mode select, sampled only during master reset |
| wen_i | input | 1 | Write enable |
| wdata_i | input | 9 | Write data |
| ren_i | input | 1 | Read enable |
| rt_i | input | 1 | Retransmit request |
| rdata_o | output | 9 | Registered output word |
| wflag_o | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| rflag_o | output | 1 | Empty (standard mode) or output ready (fall-through mode) |

## Verification

**Same-side results.** A standard-mode read shows its word on `rdata_o` one read-clock edge after `ren_i` is seen. The full flag changes on the write-clock edge of the last accepted write. A retransmit forces `rflag_o` on the very next read-clock edge. The bench drives at falling edges and samples at the falling edge right after the edge concerned.

**Cross-domain results.** Some results depend on a pointer crossing: a word becoming visible to the read side, or space becoming free again on the write side. These take two to three cycles of the destination clock. For these, the scoreboard's monitor polls the flag at each falling edge, with a bounded wait, instead of assuming a fixed delay. Every word it pops is compared in order against the queue filled by the write driver.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} mode_e;
endpackage

// File: rtl/rwf_rst_sync.sv
// Asynchronous assert, synchronous release reset conditioner.
module rwf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/rwf_sync2.sv
// Two-flop synchronizer for a Gray-coded pointer.
module rwf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/rwf_ram.sv
// Storage array: registered write, combinational read.
module rwf_ram #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rwf_wr_ctrl.sv
// Write side: pointer, Gray encode, full / input-ready flag.
module rwf_wr_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          wen,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          full,
  output logic          wflag
);
  localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s, fill;

  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  always_comb begin
    fill    = wbin_q - rbin_s;
    full    = (fill == CAP);
    we      = wen & ~full;
    wbin_d  = we ? wbin_q + (AW+1)'(1) : wbin_q;
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign wbin  = wbin_q;
  assign wgray = wgray_q;
  assign waddr = wbin_q[AW-1:0];
  assign wflag = fwft ? ~full : full;
endmodule

// File: rtl/rwf_rd_ctrl.sv
// Read side: pointer, output register, fall-through valid, retransmit hold.
module rwf_rd_ctrl #(
  parameter int AW      = 4,
  parameter int RT_HOLD = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fwft,
  input  logic                 ren,
  input  logic                 rt,
  input  logic [AW:0]          wgray_s,
  input  rwf_pkg::word_t       mem_rdata,
  output logic [AW-1:0]        raddr,
  output logic [AW:0]          rbin,
  output logic [AW:0]          rgray,
  output rwf_pkg::word_t       rdata,
  output logic                 rflag
);
  localparam int HW = $clog2(RT_HOLD + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(RT_HOLD);

  logic [AW:0]     rbin_q, rbin_d, rgray_q, rgray_d, wbin_s;
  logic [HW-1:0]   hold_q, hold_d;
  logic            ov_q, ov_d;
  rwf_pkg::word_t  dout_q, dout_d;
  logic            mem_empty, holding, take;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  always_comb begin
    mem_empty = (rbin_q == wbin_s);
    holding   = (hold_q != '0);
    take      = 1'b0;
    rbin_d    = rbin_q;
    ov_d      = ov_q;
    dout_d    = dout_q;
    hold_d    = holding ? hold_q - HW'(1) : hold_q;
    if (rt) begin
      rbin_d = '0;
      ov_d   = 1'b0;
      hold_d = HOLD_INIT;
    end else if (!holding) begin
      if (fwft) begin
        take = ~mem_empty & (~ov_q | ren);
        if (take)     ov_d = 1'b1;
        else if (ren) ov_d = 1'b0;
      end else begin
        take = ren & ~mem_empty;
      end
      if (take) begin
        rbin_d = rbin_q + (AW+1)'(1);
        dout_d = mem_rdata;
      end
    end
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      hold_q  <= '0;
      ov_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      hold_q  <= hold_d;
      ov_q    <= ov_d;
      dout_q  <= dout_d;
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rbin  = rbin_q;
  assign rgray = rgray_q;
  assign rdata = dout_q;
  assign rflag = fwft ? (ov_q & ~holding) : (mem_empty | holding);
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int ADDR_W  = 4,
  parameter int RT_HOLD = 4
) (
  input  logic                       wclk,
  input  logic                       rclk,
  input  logic                       mrst_n,
  input  logic                       prst_n,
  input  logic                       fwft_sel_i,
  input  logic                       wen_i,
  input  logic [rwf_pkg::WORD_W-1:0] wdata_i,
  input  logic                       ren_i,
  input  logic                       rt_i,
  output logic [rwf_pkg::WORD_W-1:0] rdata_o,
  output logic                       wflag_o,
  output logic                       rflag_o
);
  import rwf_pkg::*;
  localparam int PW = ADDR_W + 1;

  logic any_rst_n;
  logic w_mrst_n, w_prst_n, r_mrst_n, r_prst_n;
  mode_e w_mode_q, r_mode_q;
  logic w_fwft, r_fwft;
  logic [PW-1:0] wptr_bin, wgray, wgray_s, rptr_bin, rgray, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic we, w_full;
  word_t mem_rdata;

  assign any_rst_n = mrst_n & prst_n;

  rwf_rst_sync u_wm (.clk(wclk), .arst_n(mrst_n),    .srst_n(w_mrst_n));
  rwf_rst_sync u_wp (.clk(wclk), .arst_n(any_rst_n), .srst_n(w_prst_n));
  rwf_rst_sync u_rm (.clk(rclk), .arst_n(mrst_n),    .srst_n(r_mrst_n));
  rwf_rst_sync u_rp (.clk(rclk), .arst_n(any_rst_n), .srst_n(r_prst_n));

  // Mode is loaded only while the master reset is held in each domain.
  always_ff @(posedge wclk) begin
    if (!w_mrst_n) w_mode_q <= mode_e'(fwft_sel_i);
  end
  always_ff @(posedge rclk) begin
    if (!r_mrst_n) r_mode_q <= mode_e'(fwft_sel_i);
  end
  assign w_fwft = (w_mode_q == MODE_FWFT);
  assign r_fwft = (r_mode_q == MODE_FWFT);

  rwf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(r_prst_n), .d(wgray), .q(wgray_s));
  rwf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(w_prst_n), .d(rgray), .q(rgray_s));

  rwf_wr_ctrl #(.AW(ADDR_W)) u_wr (
    .clk(wclk), .rst_n(w_prst_n), .fwft(w_fwft), .wen(wen_i), .rgray_s(rgray_s),
    .wbin(wptr_bin), .wgray(wgray), .waddr(waddr), .we(we), .full(w_full),
    .wflag(wflag_o)
  );

  rwf_ram #(.AW(ADDR_W), .DW(WORD_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata_i),
    .raddr(raddr), .rdata(mem_rdata)
  );

  rwf_rd_ctrl #(.AW(ADDR_W), .RT_HOLD(RT_HOLD)) u_rd (
    .clk(rclk), .rst_n(r_prst_n), .fwft(r_fwft), .ren(ren_i), .rt(rt_i),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .raddr(raddr), .rbin(rptr_bin),
    .rgray(rgray), .rdata(rdata_o), .rflag(rflag_o)
  );
endmodule

// File: rtl/rwf_checker.sv
module rwf_checker #(
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          w_prst_n,
  input logic          r_prst_n,
  input logic          r_mrst_n,
  input logic          r_fwft,
  input logic          w_full,
  input logic          wen_i,
  input logic          ren_i,
  input logic          rt_i,
  input logic          rflag_o,
  input logic [8:0]    rdata_o,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin
);
  assert_no_overflow_R7: assert property (@(posedge wclk) disable iff (!w_prst_n)
    (w_full && wen_i) |=> $stable(wptr_bin));

  assert_wptr_step_R7: assert property (@(posedge wclk) disable iff (!w_prst_n)
    (wptr_bin == $past(wptr_bin)) || (wptr_bin == $past(wptr_bin) + PW'(1)));

  assert_no_underflow_R7: assert property (@(posedge rclk) disable iff (!r_prst_n)
    (!r_fwft && rflag_o && ren_i) |=> $stable(rdata_o));

  assert_rt_rewind_R8: assert property (@(posedge rclk) disable iff (!r_prst_n)
    rt_i |=> (rptr_bin == '0));

  assert_rt_flag_std_R9: assert property (@(posedge rclk) disable iff (!r_prst_n)
    (rt_i && !r_fwft) |=> rflag_o);

  assert_rt_flag_fwft_R9: assert property (@(posedge rclk) disable iff (!r_prst_n)
    (rt_i && r_fwft) |=> !rflag_o);

  assert_mode_hold_R2: assert property (@(posedge rclk) disable iff (!r_mrst_n)
    $stable(r_fwft));
endmodule

bind rewind_fifo rwf_checker #(.PW(ADDR_W + 1)) u_chk (
  .wclk(wclk), .rclk(rclk), .w_prst_n(w_prst_n), .r_prst_n(r_prst_n),
  .r_mrst_n(r_mrst_n), .r_fwft(r_fwft), .w_full(w_full), .wen_i(wen_i),
  .ren_i(ren_i), .rt_i(rt_i), .rflag_o(rflag_o), .rdata_o(rdata_o),
  .wptr_bin(wptr_bin), .rptr_bin(rptr_bin)
);

// File: tb/test_rewind_fifo.sv
`timescale 1ns/1ps
module test_rewind_fifo;
  localparam int DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic mrst_n, prst_n, fwft_sel, wen, ren, rt;
  logic [8:0] wdata, rdata;
  logic wflag, rflag;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit cur_fwft = 0;
  logic [8:0] exp_q[$];
  logic [8:0] hist[$];

  always #2 wclk = ~wclk;   // 250 MHz
  always #3 rclk = ~rclk;

  rewind_fifo i_rewind_fifo (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel_i(fwft_sel), .wen_i(wen), .wdata_i(wdata), .ren_i(ren), .rt_i(rt),
    .rdata_o(rdata), .wflag_o(wflag), .rflag_o(rflag)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic master_reset(bit fw);
    mrst_n = 0; prst_n = 1; fwft_sel = fw; wen = 0; ren = 0; rt = 0; wdata = '0;
    repeat (4) @(negedge rclk);
    mrst_n = 1;
    repeat (4) @(negedge rclk);
    cur_fwft = fw; exp_q.delete(); hist.delete();
  endtask

  task automatic partial_reset();
    prst_n = 0;
    repeat (4) @(negedge rclk);
    prst_n = 1;
    repeat (4) @(negedge rclk);
    exp_q.delete(); hist.delete();
  endtask

  // Driver: writes when the write flag allows, pushes to the scoreboard.
  task automatic wr_word(logic [8:0] d, output bit ok);
    @(negedge wclk);
    ok = cur_fwft ? wflag : !wflag;
    if (ok) begin
      wen = 1; wdata = d;
      @(negedge wclk);
      wen = 0;
      exp_q.push_back(d); hist.push_back(d);
    end
  endtask

  task automatic wr_n(int n, int base);
    for (int k = 0; k < n; k++) begin
      bit ok = 0;
      int tries = 0;
      while (!ok && tries < 100) begin wr_word(9'(base + k * 37), ok); tries++; end
    end
  endtask

  // Monitor: pops and compares as the design delivers words.
  task automatic mon_read(int n, string req);
    for (int k = 0; k < n; k++) begin
      int waited = 0;
      bit got = 0;
      while (!got && waited < 300) begin
        @(negedge rclk);
        if (cur_fwft ? rflag : !rflag) begin
          logic [8:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h000;
          if (cur_fwft) begin
            chk(req, int'(rdata), int'(e));
            ren = 1; @(negedge rclk); ren = 0;
          end else begin
            ren = 1; @(negedge rclk); ren = 0;
            chk(req, int'(rdata), int'(e));
          end
          got = 1;
        end else waited++;
      end
      if (!got) chk({req, " timeout"}, 0, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // ---- standard mode ----
    master_reset(0);
    chk("R1 rdata after master reset", int'(rdata), 0);
    chk("R4 not full after reset", int'(wflag), 0);
    chk("R4 empty after reset", int'(rflag), 1);

    wr_n(3, 9'h011);
    repeat (8) @(negedge rclk);
    chk("R5 no output without read", int'(rdata), 0);
    chk("R4 not empty with data", int'(rflag), 0);
    mon_read(3, "R5 standard read order");
    repeat (6) @(negedge rclk);
    chk("R4 empty after drain", int'(rflag), 1);
    ren = 1; @(negedge rclk); ren = 0; @(negedge rclk);
    chk("R7 read while empty ignored", int'(rdata), int'(hist[2]));

    // ---- full in standard mode ----
    partial_reset();
    chk("R3 rdata after partial reset", int'(rdata), 0);
    chk("R2 standard kept (not full)", int'(wflag), 0);
    chk("R3 empty after partial reset", int'(rflag), 1);
    wr_n(DEPTH - 1, 9'h020);
    @(negedge wclk);
    chk("R4 not full at DEPTH-1", int'(wflag), 0);
    wr_n(1, 9'h1F0);
    chk("R4 full at DEPTH", int'(wflag), 1);
    wen = 1; wdata = 9'h1AA; @(negedge wclk); wen = 0;
    mon_read(DEPTH, "R7 full store intact");
    repeat (10) @(negedge rclk);
    chk("R7 write while full dropped", int'(rflag), 1);
    chk("R7 last word unchanged", int'(rdata), int'(hist[DEPTH-1]));

    // ---- retransmit, standard ----
    partial_reset();
    wr_n(5, 9'h040);
    mon_read(3, "R5 pre-retransmit");
    @(negedge rclk);
    chk("R4 data left before rewind", int'(rflag), 0);
    rt = 1; @(negedge rclk); rt = 0;
    chk("R9 empty forced on retransmit", int'(rflag), 1);
    exp_q.delete();
    foreach (hist[i]) exp_q.push_back(hist[i]);
    wr_n(2, 9'h0C0);
    mon_read(7, "R8 standard reread");

    // ---- fall-through mode ----
    master_reset(1);
    chk("R1 rdata after master reset fwft", int'(rdata), 0);
    chk("R6 input ready after reset", int'(wflag), 1);
    chk("R6 output not ready after reset", int'(rflag), 0);
    wr_n(1, 9'h155);
    repeat (8) @(negedge rclk);
    chk("R6 fall-through ready", int'(rflag), 1);
    chk("R6 fall-through data", int'(rdata), 9'h155);
    mon_read(1, "R6 fwft consume");
    wr_n(6, 9'h061);
    mon_read(6, "R6 fwft order");

    // capacity DEPTH+1
    begin
      int acc = 0, idle = 0;
      while (idle < 40) begin
        bit ok;
        wr_word(9'(acc * 5 + 3), ok);
        if (ok) begin acc++; idle = 0; end else idle++;
      end
      chk("R6 capacity DEPTH+1", acc, DEPTH + 1);
      chk("R6 not ready when full", int'(wflag), 0);
    end
    mon_read(DEPTH + 1, "R6 fwft full drain");

    // ---- retransmit, fall-through; mode pin changed outside master reset ----
    fwft_sel = 0;
    partial_reset();
    chk("R2 fwft kept (input ready)", int'(wflag), 1);
    chk("R3 rdata after partial reset fwft", int'(rdata), 0);
    wr_n(4, 9'h081);
    mon_read(2, "R6 pre-retransmit fwft");
    repeat (2) @(negedge rclk);
    chk("R6 ready before rewind", int'(rflag), 1);
    rt = 1; @(negedge rclk); rt = 0;
    chk("R9 ready dropped on retransmit", int'(rflag), 0);
    exp_q.delete();
    foreach (hist[i]) exp_q.push_back(hist[i]);
    mon_read(4, "R8 fwft reread");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule